// File: doc/BRIEF.md
# Redundant Reference Clock Guard

This block watches two reference clock inputs and decides which of them feeds the downstream clock path. A fast, free-running monitor clock samples both inputs through synchronisers. A per-input counter measures how long each input has gone without an edge. An input that holds a level longer than a configurable number of monitor cycles is declared dead, and an active-low alarm flag is latched for it.

The controller keeps a one-bit indicator of the input now in use, plus a one-hot select for a downstream clock multiplexer. While no alarm is latched, the indicator simply tracks the primary-select input. In automatic mode, when the input in use fails and the other input is still healthy, the controller moves over to the other input and stays there. In manual mode, and whenever bypass is asserted, the indicator always equals the primary-select. When both alarms are latched, input 0 is forced.

Alarms are released only by a falling edge on the alarm-clear line. That edge produces a single-cycle clear pulse. The pulse sets both alarms inactive, reloads the indicator from the primary-select, and restarts both stall counters. An input that is still dead therefore latches its alarm again once the timeout expires.

Top module: `refclk_guard`

## Requirements
- R1: After the synchronous reset, both alarm outputs are high, `ref_ind` is 0 and `ref_sel_oh` is 2'b01.
- R2: An input that toggles with a half period shorter than `STUCK_LIMIT` monitor cycles never lowers its alarm.
- R3: An input held high, or held low, for more than `STUCK_LIMIT` monitor cycles drives its alarm output low (0 = failed) within a few cycles after the timeout.
- R4: A latched alarm stays low when its input starts toggling again, until a clear pulse occurs.
- R5: Only a falling edge on `alarm_clr_n` acts. It sets both alarm outputs high and loads `ref_ind` with `prim_sel` (0 = input 0, 1 = input 1). A rising edge, or holding the line at either level, has no effect.
- R6: When both alarms are latched, `ref_ind` is 0. This also applies when both inputs are still dead after a clear: both alarms latch again after the timeout.
- R7: While neither alarm is latched, `ref_ind` follows `prim_sel`.
- R8: In automatic mode (`auto_mode`=1, `bypass_en`=0), when the input in use fails and the other input has no alarm, `ref_ind` moves to the other input.
- R9: In automatic mode, once an alarm is latched, `ref_ind` no longer follows `prim_sel`. It may then differ from `prim_sel`.
- R10: In manual mode (`auto_mode`=0), or whenever `bypass_en`=1, `ref_ind` equals `prim_sel` unless both alarms are latched. This holds even when the selected input has failed.
- R11: `ref_sel_oh` is always one-hot. Bit 1 is set when `ref_ind`=1, and bit 0 is set when `ref_ind`=0.
- R12: After a clear, the controller can select an input whose alarm was previously latched, once that input has been restored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running monitor clock, faster than either reference |
| rst | input | 1 | Synchronous active-high reset |
| ref_in0 | input | 1 | Reference clock input 0 (asynchronous) |
| ref_in1 | input | 1 | Reference clock input 1 (asynchronous) |
| prim_sel | input | 1 | Primary input choice: 0 = input 0, 1 = input 1 |
| auto_mode | input | 1 | 1 = automatic failover, 0 = manual selection |
| bypass_en | input | 1 | 1 forces manual behaviour |
| alarm_clr_n | input | 1 | Alarm clear, acts on a falling edge (asynchronous) |
| fail0_n | output | 1 | Alarm for input 0, low = failed |
| fail1_n | output | 1 | Alarm for input 1, low = failed |
| ref_ind | output | 1 | Input currently used as reference |
| ref_sel_oh | output | 2 | One-hot select for the downstream clock multiplexer |

## Verification
The bench builds the block with `SYNC_STAGES`=2 and `STUCK_LIMIT`=12. The references toggle every 4 and every 5 monitor cycles, which keeps them well inside the timeout, while a frozen input is flagged about 15 cycles after it stops. With this short timeout the bench can exercise, within a few hundred cycles each, stuck-high and stuck-low failures, latching after recovery, failover, the both-dead relatch after a clear, and the return to a restored input. The default limit of 64 is meant for a large ratio between the monitor clock and the reference clocks.

// File: rtl/refclk_guard_pkg.sv
`timescale 1ns/1ps
package refclk_guard_pkg;
  localparam int NUM_REFS = 2;

  typedef enum logic {
    EDGE_ANY  = 1'b0,
    EDGE_FALL = 1'b1
  } edge_kind_t;

  function automatic logic [NUM_REFS-1:0] idx_to_onehot(input logic idx);
    return idx ? 2'b10 : 2'b01;
  endfunction
endpackage

// File: rtl/rcg_sync_edge.sv
`timescale 1ns/1ps
module rcg_sync_edge
  import refclk_guard_pkg::*;
#(
  parameter int         STAGES  = 2,
  parameter logic       RST_VAL = 1'b0,
  parameter edge_kind_t KIND    = EDGE_ANY
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic edge_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;
  logic              cur;

  assign cur = chain_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= {STAGES{RST_VAL}};
      prev_q  <= RST_VAL;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], d_async};
      prev_q  <= cur;
    end
  end

  generate
    if (KIND == EDGE_FALL) begin : g_fall
      assign edge_o = prev_q & ~cur;
    end else begin : g_any
      assign edge_o = prev_q ^ cur;
    end
  endgenerate
endmodule

// File: rtl/rcg_stuck_det.sv
`timescale 1ns/1ps
module rcg_stuck_det #(
  parameter int STUCK_LIMIT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic edge_i,
  output logic dead_o
);
  localparam int CW = $clog2(STUCK_LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(STUCK_LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr || edge_i) begin
      cnt_q <= '0;
    end else if (cnt_q != LIM) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign dead_o = (cnt_q == LIM);
endmodule

// File: rtl/rcg_sel_ctrl.sv
`timescale 1ns/1ps
module rcg_sel_ctrl
  import refclk_guard_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic [NUM_REFS-1:0] dead,
  input  logic                prim_sel,
  input  logic                manual,
  output logic [NUM_REFS-1:0] alarm_n,
  output logic                ind,
  output logic [NUM_REFS-1:0] sel_oh
);
  logic [NUM_REFS-1:0] alarm_q, alarm_nx;
  logic                ind_q, ind_nx;
  logic [NUM_REFS-1:0] sel_q;

  always_comb begin
    alarm_nx = clr ? {NUM_REFS{1'b1}} : (alarm_q & ~dead);
    if (alarm_nx == '0) begin
      ind_nx = 1'b0;
    end else if (manual || alarm_nx == {NUM_REFS{1'b1}}) begin
      ind_nx = prim_sel;
    end else if (!alarm_nx[ind_q] && alarm_nx[~ind_q]) begin
      ind_nx = ~ind_q;
    end else begin
      ind_nx = ind_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm_q <= {NUM_REFS{1'b1}};
      ind_q   <= 1'b0;
      sel_q   <= idx_to_onehot(1'b0);
    end else begin
      alarm_q <= alarm_nx;
      ind_q   <= ind_nx;
      sel_q   <= idx_to_onehot(ind_nx);
    end
  end

  assign alarm_n = alarm_q;
  assign ind     = ind_q;
  assign sel_oh  = sel_q;
endmodule

// File: rtl/refclk_guard.sv
`timescale 1ns/1ps
module refclk_guard
  import refclk_guard_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STUCK_LIMIT = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_in0,
  input  logic       ref_in1,
  input  logic       prim_sel,
  input  logic       auto_mode,
  input  logic       bypass_en,
  input  logic       alarm_clr_n,
  output logic       fail0_n,
  output logic       fail1_n,
  output logic       ref_ind,
  output logic [1:0] ref_sel_oh
);
  logic [NUM_REFS-1:0] refs;
  logic [NUM_REFS-1:0] ref_edge;
  logic [NUM_REFS-1:0] ref_dead;
  logic [NUM_REFS-1:0] alarm_n;
  logic                clr_pulse;
  logic                manual;

  assign refs   = {ref_in1, ref_in0};
  assign manual = ~auto_mode | bypass_en;

  rcg_sync_edge #(
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1),
    .KIND   (EDGE_FALL)
  ) i_clr_sync (
    .clk    (clk),
    .rst    (rst),
    .d_async(alarm_clr_n),
    .edge_o (clr_pulse)
  );

  for (genvar g = 0; g < NUM_REFS; g++) begin : g_ref
    rcg_sync_edge #(
      .STAGES (SYNC_STAGES),
      .RST_VAL(1'b0),
      .KIND   (EDGE_ANY)
    ) i_sync (
      .clk    (clk),
      .rst    (rst),
      .d_async(refs[g]),
      .edge_o (ref_edge[g])
    );

    rcg_stuck_det #(
      .STUCK_LIMIT(STUCK_LIMIT)
    ) i_det (
      .clk   (clk),
      .rst   (rst),
      .clr   (clr_pulse),
      .edge_i(ref_edge[g]),
      .dead_o(ref_dead[g])
    );
  end

  rcg_sel_ctrl i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr_pulse),
    .dead    (ref_dead),
    .prim_sel(prim_sel),
    .manual  (manual),
    .alarm_n (alarm_n),
    .ind     (ref_ind),
    .sel_oh  (ref_sel_oh)
  );

  assign fail0_n = alarm_n[0];
  assign fail1_n = alarm_n[1];
endmodule

// File: rtl/refclk_guard_chk.sv
`timescale 1ns/1ps
module refclk_guard_chk (
  input logic       clk,
  input logic       rst,
  input logic       prim_sel,
  input logic       auto_mode,
  input logic       bypass_en,
  input logic       fail0_n,
  input logic       fail1_n,
  input logic       ref_ind,
  input logic [1:0] ref_sel_oh,
  input logic       clr_pulse
);
  // R4: a latched alarm stays low unless a clear pulse occurs
  p_alarm0_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!fail0_n && !clr_pulse) |=> !fail0_n);
  p_alarm1_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!fail1_n && !clr_pulse) |=> !fail1_n);

  // R5: a clear pulse releases both alarms and reloads the indicator
  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    clr_pulse |=> (fail0_n && fail1_n && ref_ind == $past(prim_sel)));

  // R6: both alarms latched forces input 0
  p_both_dead_r6: assert property (@(posedge clk) disable iff (rst)
    (!fail0_n && !fail1_n) |-> !ref_ind);

  // R10: manual or bypass follows the primary select unless both are failed
  p_manual_r10: assert property (@(posedge clk) disable iff (rst)
    (!auto_mode || bypass_en) |=> (ref_ind == $past(prim_sel) || (!fail0_n && !fail1_n)));

  // R11: multiplexer select is one-hot and agrees with the indicator
  p_onehot_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot(ref_sel_oh) && (ref_sel_oh[1] == ref_ind));
endmodule

bind refclk_guard refclk_guard_chk i_chk (
  .clk       (clk),
  .rst       (rst),
  .prim_sel  (prim_sel),
  .auto_mode (auto_mode),
  .bypass_en (bypass_en),
  .fail0_n   (fail0_n),
  .fail1_n   (fail1_n),
  .ref_ind   (ref_ind),
  .ref_sel_oh(ref_sel_oh),
  .clr_pulse (clr_pulse)
);

// File: tb/test_refclk_guard.sv
`timescale 1ns/1ps
module test_refclk_guard;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_in0 = 1'b0;
  logic       ref_in1 = 1'b0;
  logic       run0 = 1'b0;
  logic       run1 = 1'b0;
  logic       prim_sel = 1'b0;
  logic       auto_mode = 1'b0;
  logic       bypass_en = 1'b0;
  logic       alarm_clr_n = 1'b1;
  logic       fail0_n, fail1_n, ref_ind;
  logic [1:0] ref_sel_oh;
  int         n_checks = 0;
  int         n_errors = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;            // 250 MHz monitor clock
  always #16 if (run0) ref_in0 = ~ref_in0;
  always #20 if (run1) ref_in1 = ~ref_in1;

  refclk_guard #(.SYNC_STAGES(2), .STUCK_LIMIT(12)) i_refclk_guard (
    .clk(clk), .rst(rst), .ref_in0(ref_in0), .ref_in1(ref_in1),
    .prim_sel(prim_sel), .auto_mode(auto_mode), .bypass_en(bypass_en),
    .alarm_clr_n(alarm_clr_n), .fail0_n(fail0_n), .fail1_n(fail1_n),
    .ref_ind(ref_ind), .ref_sel_oh(ref_sel_oh)
  );

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_clear();
    alarm_clr_n = 1'b0;
    wait_cyc(6);
  endtask

  task automatic release_clear();
    alarm_clr_n = 1'b1;
    wait_cyc(4);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    wait_cyc(4);
    check("R1 alarms", {fail1_n, fail0_n}, 2'b11);
    check("R1 ind", {1'b0, ref_ind}, 2'b00);
    check("R1 onehot", ref_sel_oh, 2'b01);
    rst = 1'b0;
    wait_cyc(2);
  endtask

  task automatic t_healthy();
    run0 = 1'b1; run1 = 1'b1;
    prim_sel = 1'b1; auto_mode = 1'b0;
    wait_cyc(60);
    check("R2 no alarm", {fail1_n, fail0_n}, 2'b11);
    check("R7 follow", {1'b0, ref_ind}, 2'b01);
    check("R11 onehot", ref_sel_oh, 2'b10);
    prim_sel = 1'b0;
    wait_cyc(3);
    check("R7 follow back", {1'b0, ref_ind}, 2'b00);
    check("R11 onehot back", ref_sel_oh, 2'b01);
    prim_sel = 1'b1;
    wait_cyc(3);
  endtask

  task automatic t_manual_fail();
    @(posedge ref_in1); run1 = 1'b0;       // stuck high
    wait_cyc(40);
    check("R3 stuck high", {fail1_n, fail0_n}, 2'b01);
    check("R10 manual keeps sel", {1'b0, ref_ind}, 2'b01);
    run1 = 1'b1;
    wait_cyc(40);
    check("R4 latched", {fail1_n, fail0_n}, 2'b01);
    auto_mode = 1'b1; bypass_en = 1'b1;
    wait_cyc(10);
    check("R10 bypass keeps sel", {1'b0, ref_ind}, 2'b01);
    bypass_en = 1'b0;
    wait_cyc(4);
    check("R8 failover to 0", {1'b0, ref_ind}, 2'b00);
    check("R11 onehot after failover", ref_sel_oh, 2'b01);
    auto_mode = 1'b0;
    wait_cyc(4);
  endtask

  task automatic t_clear_edges();
    do_clear();
    check("R5 clear alarms", {fail1_n, fail0_n}, 2'b11);
    check("R5 ind=prim", {1'b0, ref_ind}, 2'b01);
    @(negedge ref_in0); run0 = 1'b0;       // stuck low while clear held low
    wait_cyc(40);
    check("R3 stuck low", {fail1_n, fail0_n}, 2'b10);
    alarm_clr_n = 1'b1;                     // rising edge is ignored
    wait_cyc(10);
    check("R5 rising ignored", {fail1_n, fail0_n}, 2'b10);
  endtask

  task automatic t_auto();
    run0 = 1'b1;
    prim_sel = 1'b0; auto_mode = 1'b1; bypass_en = 1'b0;
    wait_cyc(10);
    do_clear();
    check("R12 restored alarms", {fail1_n, fail0_n}, 2'b11);
    check("R12 back to input 0", {1'b0, ref_ind}, 2'b00);
    release_clear();
    @(posedge ref_in0); run0 = 1'b0;
    wait_cyc(40);
    check("R3 primary failed", {fail1_n, fail0_n}, 2'b10);
    check("R8 failover to 1", {1'b0, ref_ind}, 2'b01);
    check("R11 onehot", ref_sel_oh, 2'b10);
    prim_sel = 1'b1; wait_cyc(4); prim_sel = 1'b0;
    wait_cyc(6);
    check("R9 ignores prim_sel", {1'b0, ref_ind}, 2'b01);
  endtask

  task automatic t_both_dead();
    @(negedge ref_in1); run1 = 1'b0;
    wait_cyc(40);
    check("R6 both latched", {fail1_n, fail0_n}, 2'b00);
    check("R6 ind forced 0", {1'b0, ref_ind}, 2'b00);
    prim_sel = 1'b1;
    wait_cyc(2);
    do_clear();
    check("R5 clear both", {fail1_n, fail0_n}, 2'b11);
    check("R5 ind=prim 1", {1'b0, ref_ind}, 2'b01);
    wait_cyc(40);
    check("R6 relatch", {fail1_n, fail0_n}, 2'b00);
    check("R6 relatch ind 0", {1'b0, ref_ind}, 2'b00);
    release_clear();
  endtask

  initial begin
    t_reset();
    t_healthy();
    t_manual_fail();
    t_clear_edges();
    t_auto();
    t_both_dead();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule